// File: doc/BRIEF.md
# I2C Master Receive Burst Engine

This block is the read half of an I2C master. Once a separate engine has issued the START and the address with the read bit, software or a sequencer writes one configuration word. The engine then clocks a programmed number of bytes in from the addressed target, one after another. It drives SCL, samples SDA, and answers each byte on the ninth clock with an ACK, or with a NAK on the final byte when asked to. Every received byte goes into a receive FIFO that is as deep as the longest burst.

The received bytes leave through a valid/ready stream. A byte moves on a cycle where `rd_valid` and `rd_ready` are both high, and each such handshake pops exactly one byte. When the FIFO is empty, `rd_valid` is low and `rd_data` reads as zero. Back-pressure reaches the bus: if the FIFO is full when a new byte is due, the master holds SCL low until a slot frees up. A completion flag rises once the last byte of the burst is stored. An enable can turn that flag into an interrupt. Long reads are split into chained bursts: every burst but the last keeps the NAK-last bit clear, so the target keeps sending. Between bursts the engine parks SCL low so that the next burst, or a STOP engine, can take over.

Top module: `i2crx_burst`

## Requirements
- R1: After reset `scl_o` is 1 (released), `sda_oe` is 0, `busy` is 0, `rd_done` is 0 and the FIFO is empty.
- R2: A `cfg_wr` pulse while idle starts a burst. Bits [CW-1:0] of `cfg_wdata` (CW = clog2(DEPTH)+1) give the byte count, bit 7 is the NAK-last enable, and the other bits are ignored. A count above DEPTH is treated as DEPTH.
- R3: Each byte takes nine SCL pulses. Each low phase and each high phase lasts HALF_DIV clock cycles. SDA is sampled when SCL rises, MSB first. `sda_oe` never changes while SCL is high, and SCL stays low once a burst has ended.
- R4: On the ninth pulse `sda_oe` is 1 (ACK) for every byte, except the last byte of a burst whose NAK-last enable is set, where it is 0 (NAK). `sda_oe` is 0 during data bits.
- R5: Bytes leave the stream in the order they were received, one per cycle where `rd_valid` and `rd_ready` are both high.
- R6: With the FIFO empty, `fifo_empty` is 1, `rd_valid` is 0 and `rd_data` is 0, and `rd_ready` changes no pointer.
- R7: `rd_done` goes to 1 once the last byte of a burst is in the FIFO, and stays set until the next accepted `cfg_wr`. `irq` equals `rd_done` AND `irq_en`.
- R8: A count of 0 sets `rd_done` two cycles after the write, with no SCL activity.
- R9: When the FIFO is full at the start of a byte, SCL is held low and the byte waits until a pop frees a slot. No byte is ever lost.
- R10: A `cfg_wr` that arrives while a burst is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Count in low bits, NAK-last enable in bit 7 |
| scl_o | output | 1 | SCL level, 1 = released |
| sda_oe | output | 1 | 1 = pull SDA low |
| sda_i | input | 1 | Sampled SDA level |
| rd_valid | output | 1 | Received byte available |
| rd_ready | input | 1 | Consumer takes the byte |
| rd_data | output | DW | Oldest received byte, 0 when empty |
| fifo_empty | output | 1 | Receive FIFO empty |
| busy | output | 1 | Burst in progress |
| rd_done | output | 1 | Burst complete flag |
| irq_en | input | 1 | Interrupt enable for `rd_done` |
| irq | output | 1 | Completion interrupt |

## Verification
The bench builds the engine with DEPTH = 8 and HALF_DIV = 2. That makes a count-field overflow (15 clamped to 8) and a full FIFO reachable within a few hundred cycles. A burst issued while eight bytes sit unread shows the SCL hold and its release one pop at a time. A target model on the bus shifts out known bytes and records the ninth-bit answer of each, so ACK/NAK placement, arrival order and the pulse count per byte are all checked against the configured word.

// File: rtl/i2crx_pkg.sv
package i2crx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOW  = 2'd1,
    ST_HIGH = 2'd2
  } eng_st_t;
endpackage

// File: rtl/i2crx_tick.sv
module i2crx_tick #(
  parameter int HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int TW = $clog2(HALF_DIV) + 1;
  logic [TW-1:0] cnt;

  assign tick = en && (cnt == TW'(HALF_DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (!en)  cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/i2crx_fifo.sv
module i2crx_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          out_ready,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic          empty,
  output logic          full
);
  localparam int PW = $clog2(DEPTH);
  logic [DW-1:0] mem [DEPTH];
  logic [PW:0]   wptr, rptr;
  logic          pop;

  assign empty     = (wptr == rptr);
  assign full      = (wptr[PW] != rptr[PW]) && (wptr[PW-1:0] == rptr[PW-1:0]);
  assign out_valid = !empty;
  assign out_data  = empty ? '0 : mem[rptr[PW-1:0]];
  assign pop       = out_ready && !empty;

  always_ff @(posedge clk) begin
    if (push && !full) mem[wptr[PW-1:0]] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
    end else begin
      if (push && !full) wptr <= wptr + 1'b1;
      if (pop)           rptr <= rptr + 1'b1;
    end
  end
endmodule

// File: rtl/i2crx_engine.sv
module i2crx_engine
  import i2crx_pkg::*;
#(
  parameter int DW = 8,
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] count,
  input  logic          nak_last,
  input  logic          tick,
  input  logic          sda_i,
  input  logic          room,
  output logic          run,
  output logic          scl_o,
  output logic          sda_oe,
  output logic          push,
  output logic [DW-1:0] push_data,
  output logic          busy,
  output logic          done_q
);
  localparam logic [3:0] ACKBIT = 4'(DW);

  eng_st_t       st;
  logic [3:0]    bitn;
  logic [CW-1:0] rem;
  logic [DW-1:0] shreg;
  logic          nak_q, owned, last, stall;

  assign last      = (rem == CW'(1));
  assign stall     = (st == ST_LOW) && (bitn == 4'd0) && !room;
  assign run       = (st != ST_IDLE) && !stall;
  assign busy      = (st != ST_IDLE);
  assign scl_o     = !((st == ST_LOW) || ((st == ST_IDLE) && owned));
  assign sda_oe    = (st != ST_IDLE) && (bitn == ACKBIT) && !(last && nak_q);
  assign push      = (st == ST_HIGH) && tick && (bitn == ACKBIT);
  assign push_data = shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      bitn   <= '0;
      rem    <= '0;
      shreg  <= '0;
      nak_q  <= 1'b0;
      owned  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (start) begin
            if (count == '0) begin
              done_q <= 1'b1;
            end else begin
              st    <= ST_LOW;
              bitn  <= '0;
              rem   <= count;
              nak_q <= nak_last;
              owned <= 1'b1;
            end
          end
        end
        ST_LOW: begin
          if (tick) begin
            st <= ST_HIGH;
            if (bitn != ACKBIT) shreg <= {shreg[DW-2:0], sda_i};
          end
        end
        ST_HIGH: begin
          if (tick) begin
            st <= ST_LOW;
            if (bitn == ACKBIT) begin
              bitn <= '0;
              rem  <= rem - 1'b1;
              if (last) begin
                st     <= ST_IDLE;
                done_q <= 1'b1;
              end
            end else begin
              bitn <= bitn + 1'b1;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2crx_burst.sv
module i2crx_burst #(
  parameter int DW       = 8,
  parameter int DEPTH    = 64,
  parameter int HALF_DIV = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic [7:0]    cfg_wdata,
  output logic          scl_o,
  output logic          sda_oe,
  input  logic          sda_i,
  output logic          rd_valid,
  input  logic          rd_ready,
  output logic [DW-1:0] rd_data,
  output logic          fifo_empty,
  output logic          busy,
  output logic          rd_done,
  input  logic          irq_en,
  output logic          irq
);
  localparam int CW = $clog2(DEPTH) + 1;

  logic [CW-1:0] raw_cnt, eff_cnt;
  logic          accept, w_tick, w_run, w_push, w_full, w_done;
  logic [DW-1:0] w_pdata;

  assign raw_cnt = cfg_wdata[CW-1:0];
  assign eff_cnt = (raw_cnt > CW'(DEPTH)) ? CW'(DEPTH) : raw_cnt;
  assign accept  = cfg_wr && !busy;
  assign irq     = rd_done && irq_en;

  i2crx_tick #(.HALF_DIV(HALF_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .en(w_run), .tick(w_tick)
  );

  i2crx_engine #(.DW(DW), .CW(CW)) u_eng (
    .clk(clk), .rst_n(rst_n), .start(accept), .count(eff_cnt),
    .nak_last(cfg_wdata[7]), .tick(w_tick), .sda_i(sda_i), .room(!w_full),
    .run(w_run), .scl_o(scl_o), .sda_oe(sda_oe), .push(w_push),
    .push_data(w_pdata), .busy(busy), .done_q(w_done)
  );

  i2crx_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(w_push), .push_data(w_pdata),
    .out_ready(rd_ready), .out_valid(rd_valid), .out_data(rd_data),
    .empty(fifo_empty), .full(w_full)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rd_done <= 1'b0;
    else if (accept) rd_done <= 1'b0;
    else if (w_done) rd_done <= 1'b1;
  end
endmodule

// File: rtl/i2crx_burst_chk.sv
module i2crx_burst_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_o,
  input logic          sda_oe,
  input logic          busy,
  input logic          rd_valid,
  input logic [DW-1:0] rd_data,
  input logic          rd_done,
  input logic          push,
  input logic          full,
  input logic          done_q,
  input logic [3:0]    bitn
);
  a_r3_sda_steady_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_o && $past(scl_o)) |-> $stable(sda_oe));

  a_r3_scl_low_after_burst: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !scl_o);

  a_r4_ack_only_ninth: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> (bitn == 4'(DW)));

  a_r9_push_has_room: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);

  a_r6_empty_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> (rd_data == '0));

  a_r7_done_from_engine: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_done) |-> $past(done_q));
endmodule

bind i2crx_burst i2crx_burst_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_o(scl_o), .sda_oe(sda_oe), .busy(busy),
  .rd_valid(rd_valid), .rd_data(rd_data), .rd_done(rd_done),
  .push(w_push), .full(w_full), .done_q(w_done), .bitn(u_eng.bitn)
);

// File: tb/i2crx_burst_bench.sv
`timescale 1ns/1ps
module i2crx_burst_bench;
  localparam int DW = 8, DEPTH = 8, HALF = 2;

  logic clk = 1'b0, rst_n = 1'b0, cfg_wr = 1'b0, sda_i = 1'b1;
  logic rd_ready = 1'b0, irq_en = 1'b0;
  logic [7:0] cfg_wdata = '0;
  wire scl_o, sda_oe, rd_valid, fifo_empty, busy, rd_done, irq;
  wire [DW-1:0] rd_data;

  i2crx_burst #(.DW(DW), .DEPTH(DEPTH), .HALF_DIV(HALF)) u_i2crx_burst (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .scl_o(scl_o), .sda_oe(sda_oe), .sda_i(sda_i), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .rd_data(rd_data), .fifo_empty(fifo_empty),
    .busy(busy), .rd_done(rd_done), .irq_en(irq_en), .irq(irq)
  );

  always #10 clk = ~clk;

  int errors = 0, checks = 0, cyc = 0;
  logic [7:0] slv_mem [64];
  logic       ack_log [64];
  int slv_idx = 0, bitcnt = 0, ack_n = 0, rises = 0;
  longint rise_t [2];

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // target model: drives data bits after SCL falls, logs the ninth bit
  always @(negedge scl_o) begin
    if (bitcnt < 8) sda_i = slv_mem[slv_idx % 64][7 - bitcnt];
    else            sda_i = 1'b1;
  end
  always @(posedge scl_o) begin
    if (rises < 2) rise_t[rises] = $time;
    rises++;
    if (bitcnt == 8) begin
      ack_log[ack_n % 64] = sda_oe;
      ack_n++;
      bitcnt = 0;
      slv_idx++;
    end else begin
      bitcnt++;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [7:0] w);
    @(negedge clk); cfg_wdata = w; cfg_wr = 1'b1;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic wait_done();
    int n = 0;
    while (!rd_done && n < 5000) begin @(negedge clk); n++; end
  endtask

  task automatic pop_expect(input logic [7:0] e, input string tag);
    @(negedge clk);
    chk(rd_valid && rd_data == e, tag, rd_data, e);
    rd_ready = 1'b1;
    @(negedge clk); rd_ready = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(scl_o == 1'b1, "R1 scl released", scl_o, 1);
    chk(sda_oe == 1'b0, "R1 sda released", sda_oe, 0);
    chk(busy == 1'b0 && rd_done == 1'b0, "R1 idle flags", {busy, rd_done}, 0);
    rst_n = 1'b1;
    slv_idx = 0; bitcnt = 0; ack_n = 0; rises = 0;
    @(negedge clk);
    chk(fifo_empty && !rd_valid, "R6 empty after reset", {fifo_empty, rd_valid}, 2'b10);
    rd_ready = 1'b1; @(negedge clk); rd_ready = 1'b0;
    chk(rd_data == '0 && fifo_empty, "R6 pop on empty", rd_data, 0);
  endtask

  task automatic t_burst(input logic [7:0] w, input int n, input bit nak, input bit ien, input string tag);
    int base = slv_idx, ab = ack_n;
    irq_en = ien; rises = 0;
    write_cfg(w);
    wait_done();
    chk(rd_done == 1'b1, {tag, " R7 done"}, rd_done, 1);
    chk(irq == ien, {tag, " R7 irq"}, irq, ien);
    chk(rises == 9 * n, {tag, " R2 R3 pulse count"}, rises, 9 * n);
    chk(rise_t[1] - rise_t[0] == 2 * HALF * 20, {tag, " R3 bit period"}, rise_t[1] - rise_t[0], 2 * HALF * 20);
    for (int k = 0; k < n; k++) begin
      logic e = !(nak && k == n - 1);
      chk(ack_log[(ab + k) % 64] == e, {tag, " R4 ack"}, ack_log[(ab + k) % 64], e);
    end
    for (int k = 0; k < n; k++) pop_expect(slv_mem[(base + k) % 64], {tag, " R5 order"});
    @(negedge clk);
    chk(fifo_empty && !rd_valid, {tag, " R6 drained"}, fifo_empty, 1);
  endtask

  task automatic t_zero();
    rises = 0;
    write_cfg(8'h80);
    @(negedge clk);
    chk(rd_done && !busy, "R8 zero count done", {rd_done, busy}, 2'b10);
    repeat (20) @(negedge clk);
    chk(rises == 0 && fifo_empty, "R8 no bus activity", rises, 0);
  endtask

  task automatic t_stall();
    int base = slv_idx;
    write_cfg(8'h08);
    wait_done();
    rises = 0;
    write_cfg(8'h02);
    repeat (50) @(negedge clk);
    chk(rises == 0 && scl_o == 1'b0 && busy, "R9 SCL held while full", rises, 0);
    pop_expect(slv_mem[base % 64], "R9 R5 first pop");
    repeat (60) @(negedge clk);
    chk(rises == 9 && busy, "R9 one byte then hold", rises, 9);
    pop_expect(slv_mem[(base + 1) % 64], "R9 R5 second pop");
    wait_done();
    chk(rises == 18 && rd_done, "R9 resumed burst", rises, 18);
    for (int k = 2; k < 10; k++) pop_expect(slv_mem[(base + k) % 64], "R9 R5 drain order");
    @(negedge clk);
    chk(fifo_empty, "R9 nothing lost or extra", fifo_empty, 1);
  endtask

  task automatic t_busy();
    int base = slv_idx, ab = ack_n;
    rises = 0;
    write_cfg(8'h03);
    repeat (5) @(negedge clk);
    write_cfg(8'h85);
    wait_done();
    chk(rises == 27, "R10 write while busy ignored", rises, 27);
    chk(ack_log[(ab + 2) % 64] == 1'b1, "R10 NAK bit not taken", ack_log[(ab + 2) % 64], 1);
    for (int k = 0; k < 3; k++) pop_expect(slv_mem[(base + k) % 64], "R10 R5 data");
    @(negedge clk);
    chk(fifo_empty, "R10 no extra bytes", fifo_empty, 1);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) slv_mem[i] = 8'(i * 73 + 29);
    t_reset();
    t_burst(8'h83, 3, 1'b1, 1'b1, "nak-last");
    t_burst(8'h04, 4, 1'b0, 1'b0, "all-ack");
    t_zero();
    t_burst(8'h0F, 8, 1'b0, 1'b1, "R2 clamp");
    t_burst(8'h72, 2, 1'b0, 1'b0, "R2 spare bits");
    t_stall();
    t_busy();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule